// File: doc/BRIEF.md
# Programmable Burst Column Address Sequencer

This block generates the column addresses for the data beats of a synchronous DRAM burst. A mode-load port sets the burst length, the burst order and the read latency. A command port accepts read, write and burst-stop commands. Each read or write carries a start column. While a burst runs, the block presents two column addresses every clock, one for the even beat and one for the odd beat, because data moves at double rate. It also raises a read-data-valid strobe a programmed number of clocks after a read command.

The block checks three rules and rejects any command that breaks one. A full-page burst must use sequential order. A full-page burst must start on an even column. A read may not cut short a write burst that is still running. A rejected command raises a one-clock illegal flag and changes no state. All inputs are sampled on the rising clock edge.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the mode is burst length 2, sequential order, read latency 3; `busy`, `beat_vld`, `rd_valid` and `illegal` are 0.
- R2: `mode_bl` encodes the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8, 3 gives a full page. A burst of N fixed beats holds `beat_vld` high for N/2 clocks, starting in the clock after the command edge. Each clock carries beat 2j on `beat_col_e` and beat 2j+1 on `beat_col_o`.
- R3: With `mode_il`=0 (sequential order) and a fixed length L, beat i uses column (start & ~(L-1)) | ((start+i) mod L). The bits above the block of size L stay equal to the start column.
- R4: With `mode_il`=1 (interleaved order) and a fixed length L, beat i uses column (start & ~(L-1)) | ((start XOR i) & (L-1)).
- R5: A full-page burst uses sequential order over 256 columns. Beat i uses column (start+i) mod 256. The burst runs until it is ended by a stop command or by a new accepted read or write.
- R6: A mode load that asks for a full page together with interleaved order raises `illegal` for one clock, and the previous mode is kept.
- R7: A read or write given with a full-page mode and an odd start column raises `illegal` and starts no burst.
- R8: A read given while a write burst is active raises `illegal`. The write burst goes on to its normal end with its original addresses.
- R9: `mode_rl`=0 selects read latency 3 and `mode_rl`=1 selects latency 4. `rd_valid` is high from the clock that comes that many clocks after the read command edge, and stays high for the burst's number of clocks.
- R10: `cmd` encodes 1 as read, 2 as write and 3 as stop. A stop ends the active burst at its edge. An accepted read or write during a burst ends that burst and starts the new one in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Loads the mode fields below |
| mode_bl | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=full page |
| mode_il | input | 1 | Burst order: 0 sequential, 1 interleaved |
| mode_rl | input | 1 | Read latency: 0 gives 3 clocks, 1 gives 4 clocks |
| cmd | input | 2 | Command: 0 none, 1 read, 2 write, 3 stop |
| start_col | input | COL_W | Start column for read or write |
| beat_vld | output | 1 | A beat pair is presented this clock |
| beat_wr | output | 1 | The current beat pair belongs to a write |
| beat_col_e | output | COL_W | Column of the even beat |
| beat_col_o | output | COL_W | Column of the odd beat |
| rd_valid | output | 1 | Read data valid, delayed by the read latency |
| busy | output | 1 | A burst is active |
| illegal | output | 1 | One-clock pulse for a rejected mode load or command |

## Verification
Directed bursts use a different length, order and start column for each case. The case with start 0x13 and length 4 shows whether addresses wrap inside their aligned block or carry into the upper bits. The case with start 0x2D and length 8, interleaved, tells XOR order apart from addition. A full-page write from 0xFE runs past 256 beats, which checks the wrap at the page edge and the stop command. Latency runs at 3 and at 4 clocks are checked on every clock around the data window. Interrupt cases separate a rejected read during a write from a write that replaces an active read.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ld,
  input  logic [1:0]       mode_bl,
  input  logic             mode_il,
  input  logic             mode_rl,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] start_col,
  output logic             beat_vld,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col_e,
  output logic [COL_W-1:0] beat_col_o,
  output logic             rd_valid,
  output logic             busy,
  output logic             illegal
);
  localparam int PAIR_W = COL_W - 1;
  localparam logic [1:0] BL_FULL  = 2'b11;
  localparam logic [1:0] CMD_RD   = 2'b01;
  localparam logic [1:0] CMD_WR   = 2'b10;
  localparam logic [1:0] CMD_STOP = 2'b11;

  logic [1:0]        m_bl;
  logic              m_il, m_rl;
  logic              b_act, b_wr, b_il, b_rl;
  logic [1:0]        b_bl;
  logic [PAIR_W-1:0] b_cnt, last_cnt;
  logic [COL_W-1:0]  b_base, mask;
  logic [3:0]        rdq_v, rdq_l;

  logic is_rd, is_wr, is_stop, odd_fp, rd_blk, go, bad_mode, ill_now, done;

  assign is_rd    = cmd == CMD_RD;
  assign is_wr    = cmd == CMD_WR;
  assign is_stop  = cmd == CMD_STOP;
  assign odd_fp   = (m_bl == BL_FULL) && start_col[0];
  assign rd_blk   = b_act && b_wr;
  assign go       = ((is_rd && !rd_blk) || is_wr) && !odd_fp;
  assign bad_mode = mode_ld && (mode_bl == BL_FULL) && mode_il;
  assign ill_now  = bad_mode || ((is_rd || is_wr) && odd_fp) || (is_rd && rd_blk);

  always_comb begin
    case (b_bl)
      2'd0:    begin last_cnt = '0;            mask = COL_W'(1); end
      2'd1:    begin last_cnt = PAIR_W'(1);    mask = COL_W'(3); end
      2'd2:    begin last_cnt = PAIR_W'(3);    mask = COL_W'(7); end
      default: begin last_cnt = '1;            mask = '1;        end
    endcase
  end

  assign done = b_act && (b_bl != BL_FULL) && (b_cnt == last_cnt);

  function automatic logic [COL_W-1:0] col_of(input logic [COL_W-1:0] base,
                                               input logic [COL_W-1:0] idx,
                                               input logic [COL_W-1:0] msk,
                                               input logic             il);
    logic [COL_W-1:0] off;
    off = il ? (base ^ idx) : (base + idx);
    return (base & ~msk) | (off & msk);
  endfunction

  assign beat_col_e = col_of(b_base, {b_cnt, 1'b0}, mask, b_il);
  assign beat_col_o = col_of(b_base, {b_cnt, 1'b1}, mask, b_il);
  assign beat_vld   = b_act;
  assign beat_wr    = b_act && b_wr;
  assign busy       = b_act;
  assign rd_valid   = (rdq_v[2] && !rdq_l[2]) || (rdq_v[3] && rdq_l[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_bl    <= 2'd0;
      m_il    <= 1'b0;
      m_rl    <= 1'b0;
      b_act   <= 1'b0;
      b_wr    <= 1'b0;
      b_il    <= 1'b0;
      b_rl    <= 1'b0;
      b_bl    <= 2'd0;
      b_cnt   <= '0;
      b_base  <= '0;
      rdq_v   <= '0;
      rdq_l   <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= ill_now;
      rdq_v   <= {rdq_v[2:0], b_act && !b_wr};
      rdq_l   <= {rdq_l[2:0], b_rl};
      if (mode_ld && !bad_mode) begin
        m_bl <= mode_bl;
        m_il <= mode_il;
        m_rl <= mode_rl;
      end
      if (go) begin
        b_act  <= 1'b1;
        b_wr   <= is_wr;
        b_bl   <= m_bl;
        b_il   <= m_il;
        b_rl   <= m_rl;
        b_cnt  <= '0;
        b_base <= start_col;
      end else if (is_stop || done) begin
        b_act <= 1'b0;
      end else if (b_act) begin
        b_cnt <= b_cnt + PAIR_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_ld,
  input logic [1:0]       mode_bl,
  input logic             mode_il,
  input logic [1:0]       cmd,
  input logic [COL_W-1:0] start_col,
  input logic             beat_vld,
  input logic             beat_wr,
  input logic [COL_W-1:0] beat_col_e,
  input logic [COL_W-1:0] beat_col_o,
  input logic             rd_valid,
  input logic             busy,
  input logic             illegal,
  input logic [1:0]       m_bl
);
  // R8
  rd_in_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && beat_wr && cmd == 2'b01) |=> illegal);

  // R8
  rd_in_wr_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && beat_wr && cmd == 2'b01) |=> !(beat_vld && !beat_wr));

  // R7
  odd_full_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 2'b01 || cmd == 2'b10) && m_bl == 2'b11 && start_col[0]) |=> illegal);

  // R6
  bad_mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ld && mode_bl == 2'b11 && mode_il) |=> (illegal && m_bl == $past(m_bl)));

  // R9
  rd_valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(beat_vld && !beat_wr, 3) || $past(beat_vld && !beat_wr, 4)));

  // R3
  pair_upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> (beat_col_e[COL_W-1:3] == beat_col_o[COL_W-1:3]));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_bl(mode_bl), .mode_il(mode_il),
  .cmd(cmd), .start_col(start_col), .beat_vld(beat_vld), .beat_wr(beat_wr),
  .beat_col_e(beat_col_e), .beat_col_o(beat_col_o), .rd_valid(rd_valid),
  .busy(busy), .illegal(illegal), .m_bl(m_bl)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ld = 1'b0;
  logic [1:0] mode_bl = 2'd0;
  logic       mode_il = 1'b0;
  logic       mode_rl = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] start_col = 8'd0;
  logic       beat_vld, beat_wr, rd_valid, busy, illegal;
  logic [7:0] beat_col_e, beat_col_o;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic [1:0] tm_bl = 2'd0;
  logic       tm_il = 1'b0;
  logic       tm_rl = 1'b0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_bl(mode_bl), .mode_il(mode_il),
    .mode_rl(mode_rl), .cmd(cmd), .start_col(start_col), .beat_vld(beat_vld),
    .beat_wr(beat_wr), .beat_col_e(beat_col_e), .beat_col_o(beat_col_o),
    .rd_valid(rd_valid), .busy(busy), .illegal(illegal)
  );

  function automatic logic [7:0] ecol(input logic [7:0] base, input logic [7:0] i,
                                      input logic [1:0] bl, input logic il);
    logic [7:0] m, off;
    m = (bl == 2'd0) ? 8'h01 : (bl == 2'd1) ? 8'h03 : (bl == 2'd2) ? 8'h07 : 8'hFF;
    off = il ? (base ^ i) : (base + i);
    return (base & ~m) | (off & m);
  endfunction

  function automatic int npairs(input logic [1:0] bl);
    return (bl == 2'd0) ? 1 : (bl == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_mode(input logic [1:0] bl, input logic il, input logic rl);
    @(negedge clk);
    mode_ld = 1'b1; mode_bl = bl; mode_il = il; mode_rl = rl;
    @(negedge clk);
    mode_ld = 1'b0;
    chk("R6", "illegal after mode load", int'(illegal), int'(bl == 2'd3 && il));
    if (!(bl == 2'd3 && il)) begin
      tm_bl = bl; tm_il = il; tm_rl = rl;
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] col);
    @(negedge clk);
    cmd = c; start_col = col;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic check_pairs(input int j0, input int np, input logic [7:0] base,
                             input logic [1:0] bl, input logic il, input logic wr,
                             input string req);
    for (int j = j0; j < np; j++) begin
      if (j != j0) @(negedge clk);
      chk(req, $sformatf("beat_vld pair %0d", j), int'(beat_vld), 1);
      chk(req, $sformatf("beat_wr pair %0d", j), int'(beat_wr), int'(wr));
      chk(req, $sformatf("even col pair %0d", j), int'(beat_col_e),
          int'(ecol(base, 8'(2 * j), bl, il)));
      chk(req, $sformatf("odd col pair %0d", j), int'(beat_col_o),
          int'(ecol(base, 8'(2 * j + 1), bl, il)));
    end
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    chk(req, "beat_vld after burst", int'(beat_vld), 0);
    chk(req, "busy after burst", int'(busy), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "beat_vld", int'(beat_vld), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "illegal", int'(illegal), 0);
  endtask

  task automatic t_default_read;
    issue(2'd1, 8'h05);
    check_pairs(0, 1, 8'h05, 2'd0, 1'b0, 1'b0, "R1");
    expect_idle("R2");
    idle(6);
  endtask

  task automatic t_seq4;
    load_mode(2'd1, 1'b0, 1'b0);
    issue(2'd2, 8'h13);
    check_pairs(0, 2, 8'h13, 2'd1, 1'b0, 1'b1, "R3");
    expect_idle("R2");
  endtask

  task automatic t_il8;
    load_mode(2'd2, 1'b1, 1'b0);
    issue(2'd1, 8'h2D);
    check_pairs(0, 4, 8'h2D, 2'd2, 1'b1, 1'b0, "R4");
    expect_idle("R2");
    idle(6);
  endtask

  task automatic t_bad_mode;
    load_mode(2'd3, 1'b1, 1'b0);
    issue(2'd1, 8'h2D);
    check_pairs(0, 4, 8'h2D, tm_bl, tm_il, 1'b0, "R6");
    expect_idle("R6");
    idle(6);
  endtask

  task automatic t_latency(input logic rl);
    int lat, np;
    load_mode(2'd1, 1'b0, rl);
    lat = rl ? 4 : 3;
    np = npairs(2'd1);
    issue(2'd1, 8'h00);
    for (int t = 0; t < lat + np + 2; t++) begin
      if (t != 0) @(negedge clk);
      chk("R9", $sformatf("rd_valid lat %0d clock %0d", lat, t), int'(rd_valid),
          int'(t >= lat && t < lat + np));
    end
    idle(4);
  endtask

  task automatic t_full_page;
    load_mode(2'd3, 1'b0, 1'b0);
    issue(2'd2, 8'hFE);
    check_pairs(0, 130, 8'hFE, 2'd3, 1'b0, 1'b1, "R5");
    issue(2'd3, 8'h00);
    chk("R10", "beat_vld after stop", int'(beat_vld), 0);
    chk("R10", "busy after stop", int'(busy), 0);
  endtask

  task automatic t_odd_full;
    issue(2'd1, 8'h11);
    chk("R7", "illegal on odd full page", int'(illegal), 1);
    chk("R7", "busy on odd full page", int'(busy), 0);
    @(negedge clk);
    chk("R7", "no burst next clock", int'(beat_vld), 0);
    chk("R7", "illegal is a pulse", int'(illegal), 0);
  endtask

  task automatic t_rd_in_wr;
    load_mode(2'd2, 1'b0, 1'b0);
    issue(2'd2, 8'h40);
    issue(2'd1, 8'h00);
    chk("R8", "illegal on read during write", int'(illegal), 1);
    check_pairs(2, 4, 8'h40, 2'd2, 1'b0, 1'b1, "R8");
    expect_idle("R8");
    idle(6);
  endtask

  task automatic t_restart;
    issue(2'd1, 8'h10);
    chk("R10", "read pair 0 before restart", int'(beat_col_e), 8'h10);
    issue(2'd2, 8'h33);
    chk("R10", "no illegal on write over read", int'(illegal), 0);
    check_pairs(0, 4, 8'h33, 2'd2, 1'b0, 1'b1, "R10");
    expect_idle("R10");
    idle(6);
  endtask

  task automatic t_stop_fixed;
    issue(2'd1, 8'h08);
    issue(2'd3, 8'h00);
    chk("R10", "beat_vld after stop on fixed burst", int'(beat_vld), 0);
    idle(6);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_default_read;
    t_seq4;
    t_il8;
    t_bad_mode;
    t_latency(1'b0);
    t_latency(1'b1);
    t_full_page;
    t_odd_full;
    t_rd_in_wr;
    t_restart;
    t_stop_fixed;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule